// File: doc/BRIEF.md
# Serial Flash Read Command Responder

This block acts as the memory side of a serial flash link, so that a host SPI controller can be exercised without a real part. It watches chip select, the serial clock and four data lines through a fast system clock. It recognises two read commands. The quad-output read (0x6B) takes its address on one line and returns data on four lines. The dual read (0xBB) takes both address and mode bits on two lines and returns data on two lines. Data bytes come from a synchronous byte-wide memory port, and the responder fetches one byte ahead of the serial output.

A dual read carries a mode byte after its address. If the upper nibble of that byte is 0xA, the responder enters continuous mode. The next transaction then skips the command byte and begins directly with the dual address. Any other mode byte ends continuous mode. A dual transaction with address 0xFFFFFF and mode 0xFF serves as the mode-reset sequence: it produces no output and returns the responder to command decoding.

The controller has seven states:
- ST_IDLE: chip select is high.
- ST_CMD: the command byte is being collected.
- ST_ADDR: the address is being collected.
- ST_MODE: the dual mode byte is being collected.
- ST_DUMMY: the quad dummy clocks are running.
- ST_DATA: data is being driven.
- ST_IGNORE: the rest of the transaction is ignored.

The transitions are as follows:
- Chip select high sends every state to ST_IDLE.
- When chip select goes low, ST_IDLE moves to ST_ADDR if continuous mode is set, and to ST_CMD otherwise.
- ST_CMD moves to ST_ADDR on a known command and to ST_IGNORE on any other byte.
- ST_ADDR moves to ST_DUMMY for a quad read and to ST_MODE for a dual read.
- ST_MODE moves to ST_DATA, or to ST_IGNORE when the reset pattern is seen.
- ST_DUMMY moves to ST_DATA.

Top module: `flash_read_responder`

## Requirements
- R1: After reset, and whenever the responder is not driving data (chip select high, or any phase before data), io_oe is 0 and io_out is 0. No memory read is issued during reset.
- R2: The first 8 rising SCLK edges after chip select falls shift a command byte in from IO0, MSB first. 0x6B selects a quad read and 0xBB selects a dual read.
- R3: A quad read takes 24 address bits on IO0, MSB first. It then waits 8 dummy clocks. It then drives each byte as two nibbles, high nibble first, on IO3..IO0 (IO3 carries the top bit of the nibble), with io_oe = 4'hF.
- R4: A dual read takes the address over 12 clocks on two lines, with IO1 carrying the higher bit of each pair. It then takes the mode byte over 4 clocks in the same way. It then drives each byte as 4 bit pairs, MSB pair first, with IO1 carrying the higher bit and io_oe = 4'b0011.
- R5: Output data changes only after falling SCLK edges and holds across the following rising edge. The first unit appears after the fall that follows the last dummy or mode clock.
- R6: Successive bytes come from successive addresses, starting at any byte. The address wraps from 0xFFFFFF to 0x000000. Each byte is fetched with one memory read whose data is used one system clock later.
- R7: A mode byte with upper nibble 0xA makes the next transaction start directly with the dual address phase, with no command byte.
- R8: A mode byte with any other upper nibble makes the next transaction expect a command byte again.
- R9: A dual transaction with address 0xFFFFFF and mode 0xFF drives no data and clears continuous mode, so the next transaction is decoded as a command.
- R10: A command byte other than 0x6B or 0xBB makes the responder drive nothing and read nothing until chip select rises.
- R11: Chip select rising releases io_oe at once and aborts the transfer. The next transaction starts fresh, byte aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial interface |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host, idles low |
| io_in | input | 4 | Data line levels as driven by the host |
| io_out | output | 4 | Data line values driven by the responder |
| io_oe | output | 4 | Per-line output enable |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 24 | Byte address for the read |
| mem_data | input | 8 | Read data, valid the clock after mem_rd |

## Verification
An SCLK edge becomes visible to the responder at the first system clock that samples the new level. The output lanes update at that same edge, so new data is present one system clock after each falling SCLK edge. A memory byte is needed one clock after its strobe, and both delays are far shorter than a half SCLK period of four system clocks. The bench therefore compares io_oe and io_out against its own expected byte stream four clocks into each low half period, just before raising SCLK. It compares them again inside the high half to show they hold across the rising edge, and it checks release directly after chip select rises.

// File: rtl/frr_pkg.sv
package frr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } frr_state_t;

    localparam logic [7:0] CMD_QUAD_RD = 8'h6B;
    localparam logic [7:0] CMD_DUAL_RD = 8'hBB;
    localparam logic [3:0] CONT_KEY    = 4'hA;
endpackage

// File: rtl/frr_edge.sv
module frr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk && !sclk_q && !cs_n;
    assign fall = !sclk && sclk_q && !cs_n;
endmodule

// File: rtl/frr_serializer.sv
module frr_serializer #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              active,
    input  logic              fall,
    input  logic              quad,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        lanes,
    output logic              on
);
    localparam int Q_UNITS = DATA_W / 4;
    localparam int D_UNITS = DATA_W / 2;
    localparam int PW      = $clog2(D_UNITS);

    logic [ADDR_W-1:0] nxt_q;
    logic [DATA_W-1:0] buf_q, sh_q, src;
    logic [PW-1:0]     pos_q;
    logic              pend_q;
    logic              take;

    assign take     = active && fall && (pos_q == '0);
    assign mem_rd   = start || take;
    assign mem_addr = start ? start_addr : nxt_q;
    assign src      = (pos_q == '0) ? buf_q : sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_q  <= '0;
            buf_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= mem_rd;
            if (mem_rd) nxt_q <= mem_addr + ADDR_W'(1);
            if (pend_q) buf_q <= mem_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            pos_q <= '0;
            lanes <= '0;
            on    <= 1'b0;
        end else if (abort) begin
            pos_q <= '0;
            on    <= 1'b0;
        end else if (active && fall) begin
            on    <= 1'b1;
            lanes <= quad ? src[DATA_W-1 -: 4] : {2'b00, src[DATA_W-1 -: 2]};
            sh_q  <= quad ? (src << 4) : (src << 2);
            if (pos_q == '0) pos_q <= quad ? PW'(Q_UNITS - 1) : PW'(D_UNITS - 1);
            else             pos_q <= pos_q - PW'(1);
        end
    end

    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R6
endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
    import frr_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int DATA_W     = 8,
    parameter int CMD_BITS   = 8,
    parameter int DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [3:0]        io_in,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data
);
    localparam int CNT_W      = $clog2(ADDR_W + 1);
    localparam int CMD_LAST   = CMD_BITS - 1;
    localparam int QADDR_LAST = ADDR_W - 1;
    localparam int DADDR_LAST = ADDR_W / 2 - 1;
    localparam int MODE_LAST  = DATA_W / 2 - 1;
    localparam int DUMMY_LAST = DUMMY_CLKS - 1;

    frr_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] shin_q, shin_1, shin_2, addr_q;
    logic              quad_q, cont_q, start_q;
    logic              sclk_rise, sclk_fall, phase_done, phase_end;
    logic              known_cmd, reset_pat;
    logic [3:0]        lanes;
    logic              lane_on;

    frr_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .cs_n (cs_n),
        .sclk (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    assign shin_1    = {shin_q[ADDR_W-2:0], io_in[0]};
    assign shin_2    = {shin_q[ADDR_W-3:0], io_in[1], io_in[0]};
    assign known_cmd = (shin_1[7:0] == CMD_QUAD_RD) || (shin_1[7:0] == CMD_DUAL_RD);
    assign reset_pat = (shin_2[DATA_W-1:0] == '1) && (addr_q == '1);

    always_comb begin
        unique case (state_q)
            ST_CMD:   phase_done = (cnt_q == CNT_W'(CMD_LAST));
            ST_ADDR:  phase_done = quad_q ? (cnt_q == CNT_W'(QADDR_LAST))
                                          : (cnt_q == CNT_W'(DADDR_LAST));
            ST_MODE:  phase_done = (cnt_q == CNT_W'(MODE_LAST));
            ST_DUMMY: phase_done = (cnt_q == CNT_W'(DUMMY_LAST));
            default:  phase_done = 1'b0;
        endcase
    end
    assign phase_end = sclk_rise && phase_done;

    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = cont_q ? ST_ADDR : ST_CMD;
                ST_CMD:    if (phase_end) state_d = known_cmd ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (phase_end) state_d = quad_q ? ST_DUMMY : ST_MODE;
                ST_MODE:   if (phase_end) state_d = reset_pat ? ST_IGNORE : ST_DATA;
                ST_DUMMY:  if (phase_end) state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shin_q  <= '0;
            addr_q  <= '0;
            quad_q  <= 1'b0;
            cont_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                if (!cs_n && cont_q) quad_q <= 1'b0;
            end else if (sclk_rise) begin
                case (state_q)
                    ST_CMD: begin
                        cnt_q  <= phase_done ? '0 : cnt_q + CNT_W'(1);
                        shin_q <= shin_1;
                        if (phase_done) quad_q <= (shin_1[7:0] == CMD_QUAD_RD);
                    end
                    ST_ADDR: begin
                        cnt_q  <= phase_done ? '0 : cnt_q + CNT_W'(1);
                        shin_q <= quad_q ? shin_1 : shin_2;
                        if (phase_done) begin
                            addr_q  <= quad_q ? shin_1 : shin_2;
                            start_q <= 1'b1;
                        end
                    end
                    ST_MODE: begin
                        cnt_q  <= phase_done ? '0 : cnt_q + CNT_W'(1);
                        shin_q <= shin_2;
                        if (phase_done) cont_q <= (shin_2[DATA_W-1 -: 4] == CONT_KEY);
                    end
                    ST_DUMMY: cnt_q <= phase_done ? '0 : cnt_q + CNT_W'(1);
                    default: ;
                endcase
            end
        end
    end

    frr_serializer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (cs_n),
        .active    (state_q == ST_DATA),
        .fall      (sclk_fall),
        .quad      (quad_q),
        .start     (start_q),
        .start_addr(addr_q),
        .mem_data  (mem_data),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .lanes     (lanes),
        .on        (lane_on)
    );

    assign io_oe  = (lane_on && !cs_n) ? (quad_q ? 4'hF : 4'h3) : 4'h0;
    assign io_out = lanes & io_oe;

    AST_OE_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DATA) |-> (io_oe == 4'h0)); // R1
    AST_IGNORE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !mem_rd); // R10
    AST_CONT_FROM_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cont_q) |-> ($past(state_q) == ST_MODE)); // R7
    AST_NO_ABORTED_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_oe[0]) |-> (state_q == ST_DATA)); // R5
endmodule

// File: tb/tb_flash_read_responder.sv
module tb_flash_read_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic [3:0]  io_in = 4'h0;
    logic [3:0]  io_out, io_oe;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic [7:0]  mem_data = 8'h00;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flash_read_responder dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
        .io_out(io_out), .io_oe(io_oe), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_data(mem_data)
    );

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hC3;
    endfunction

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_data <= memf(mem_addr);
            reads    <= reads + 1;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [3:0] drv, input logic [3:0] eoe,
                        input logic [3:0] eout, input string req);
        io_in = drv;
        repeat (4) @(negedge clk);
        chk({4'h0, io_oe}, {4'h0, eoe}, req);
        chk({4'h0, io_out}, {4'h0, eout}, req);
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        chk({4'h0, io_out}, {4'h0, eout}, "R5 hold across rise");
        repeat (2) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic cs_low();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        #1;
        chk({4'h0, io_oe}, 8'h00, "R11 release on cs rise");
        repeat (6) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int i = 7; i >= 0; i--) tick({3'b000, c[i]}, 4'h0, 4'h0, "R2 cmd phase");
    endtask

    task automatic send_addr_q(input logic [23:0] a);
        for (int i = 23; i >= 0; i--) tick({3'b000, a[i]}, 4'h0, 4'h0, "R3 addr phase");
    endtask

    task automatic send_addr_d(input logic [23:0] a);
        for (int i = 11; i >= 0; i--) tick({2'b00, a[2*i+1], a[2*i]}, 4'h0, 4'h0, "R4 addr phase");
    endtask

    task automatic send_mode(input logic [7:0] m);
        for (int i = 3; i >= 0; i--) tick({2'b00, m[2*i+1], m[2*i]}, 4'h0, 4'h0, "R4 mode phase");
    endtask

    task automatic silent(input int n, input string req);
        for (int i = 0; i < n; i++) tick(4'h0, 4'h0, 4'h0, req);
    endtask

    task automatic read_q(input logic [23:0] a, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = memf(a + 24'(k));
            tick(4'h0, 4'hF, b[7:4], req);
            tick(4'h0, 4'hF, b[3:0], req);
        end
    endtask

    task automatic read_d(input logic [23:0] a, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = memf(a + 24'(k));
            for (int j = 3; j >= 0; j--) tick(4'h0, 4'h3, {2'b00, b[2*j+1], b[2*j]}, req);
        end
    endtask

    task automatic quad_txn(input logic [23:0] a, input int n, input string req);
        cs_low();
        send_cmd(8'h6B);
        send_addr_q(a);
        silent(8, "R3 dummy phase");
        read_q(a, n, req);
        cs_high();
    endtask

    task automatic dual_txn(input bit with_cmd, input logic [23:0] a,
                            input logic [7:0] m, input int n, input string req);
        cs_low();
        if (with_cmd) send_cmd(8'hBB);
        send_addr_d(a);
        send_mode(m);
        read_d(a, n, req);
        cs_high();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        chk({4'h0, io_oe}, 8'h00, "R1 oe in reset");
        chk({7'h0, mem_rd}, 8'h00, "R1 no read in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({4'h0, io_oe}, 8'h00, "R1 oe idle");
        chk({4'h0, io_out}, 8'h00, "R1 out idle");

        quad_txn(24'h000123, 5, "R3 quad data");
        quad_txn(24'hFFFFFE, 4, "R6 wrap quad data");

        dual_txn(1'b1, 24'h0A0B0C, 8'h00, 3, "R4 dual data");
        cs_low();
        send_addr_d(24'h000000);
        send_mode(8'h00);
        silent(12, "R8 command expected");
        cs_high();

        dual_txn(1'b1, 24'h000040, 8'hA5, 2, "R4 dual data mode A5");
        dual_txn(1'b0, 24'h001234, 8'hAF, 3, "R7 continuous entry");
        dual_txn(1'b0, 24'h002000, 8'h10, 2, "R7 continuous entry 2");
        dual_txn(1'b1, 24'h003000, 8'h00, 1, "R8 command after clear");

        dual_txn(1'b1, 24'h004000, 8'hA0, 1, "R7 set again");
        cs_low();
        send_addr_d(24'hFFFFFF);
        send_mode(8'hFF);
        silent(16, "R9 reset drives nothing");
        cs_high();
        quad_txn(24'h000777, 2, "R9 normal decode after reset");

        r0 = reads;
        cs_low();
        send_cmd(8'h03);
        silent(40, "R10 unknown command");
        cs_high();
        chk(8'(reads - r0), 8'h00, "R10 no memory reads");

        cs_low();
        send_cmd(8'h6B);
        send_addr_q(24'h0000F0);
        silent(8, "R3 dummy phase");
        read_q(24'h0000F0, 1, "R11 before abort");
        tick(4'h0, 4'hF, memf(24'h0000F1) >> 4, "R11 partial byte");
        cs_high();
        quad_txn(24'h000200, 2, "R11 fresh after abort");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule